// File: doc/BRIEF.md
# Reusable Sense-Flipping Barrier

This block lets a fixed group of requesters meet at a common point before any of them continues. Each requester sends a one-cycle arrive pulse. Then it waits for its own release bit. The block counts the arrivals of the current round. When the last member of the group arrives, the block clears the count and inverts a shared phase bit in the same clock edge. Each requester stored the phase bit as it stood when it arrived. Its release bit is high while the shared phase differs from that stored copy.

Because the release condition is a phase mismatch and not a flag that is set and later cleared, the barrier can be reused at once. A requester that is slow to notice its release stays released while the others start the next round. It only loses its release bit when it arrives again.

The block ignores a repeated arrive pulse from a requester that has already arrived in the current round, and it raises a sticky error bit. Several requesters may arrive in the same cycle.

Top module: `episode_barrier`

## Requirements
- R1: After reset the phase output is 0, every release bit is 0 and the error bit is 0.
- R2: No release bit rises while fewer than all N_REQ requesters have arrived in the current round.
- R3: One cycle after the arrive pulse that completes a round, the phase output is inverted and every release bit is 1.
- R4: A requester that arrives stores the current phase. Its release bit is 0 in the cycle after that arrival unless the arrival completed the round.
- R5: Arrivals from several requesters in one cycle are all counted. N_REQ arrive bits high in one cycle complete a round.
- R6: An arrive pulse from a requester that has already arrived in the current round is not counted. The error bit is 1 from the following cycle.
- R7: Once set, the error bit stays 1 until reset.
- R8: Back-to-back rounds work. A released requester that has not arrived again keeps its release bit at 1 while the other requesters arrive for the next round.
- R9: A repeated arrival in the same cycle as the completing arrival does not stop completion and is not carried into the next round. The repeating requester's release bit stays 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| arrive_i | input | N_REQ | One-cycle arrive pulse per requester (bit i = requester i) |
| phase_o | output | 1 | Shared phase bit, inverted at each round completion |
| release_o | output | N_REQ | Registered release bit per requester |
| dup_err_o | output | 1 | Sticky flag for a repeated arrival within a round |

## Verification
Round completion can fall in the same cycle as either a batch of simultaneous arrivals or a repeated arrival. Both overlaps are driven on purpose.

- **Simultaneous arrivals:** all four requesters pulse together. Completion is judged by the inverted phase and the full release vector one cycle later.
- **Repeated arrival:** a repeat from an earlier arriver is placed in the same pulse as the final arrival. Completion and the error bit are checked first. The bench then drives three of the requesters in the next round. It observes that the repeating requester's release bit stays 1 and that the round does not complete early, which shows the repeat was neither counted nor latched.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
  // Width of a counter able to hold the values 0..n
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/arrival_filter.sv
module arrival_filter #(
  parameter int unsigned N_REQ = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_REQ-1:0] arrive,
  input  logic [N_REQ-1:0] arrived_q,
  output logic [N_REQ-1:0] take,
  output logic             err_q
);
  logic [N_REQ-1:0] repeat_hit;

  // Only requesters not yet counted this round are accepted
  always_comb begin
    take       = arrive & ~arrived_q;
    repeat_hit = arrive & arrived_q;
  end

  always_ff @(posedge clk) begin
    if (rst)              err_q <= 1'b0;
    else if (|repeat_hit) err_q <= 1'b1;
  end
endmodule

// File: rtl/arrival_counter.sv
module arrival_counter
  import barrier_pkg::*;
#(
  parameter int unsigned N_REQ = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_REQ-1:0] take,
  output logic             done,
  output logic             phase_q
);
  localparam int unsigned CNT_W = cnt_width(N_REQ);
  localparam logic [CNT_W:0] FULL = (CNT_W + 1)'(N_REQ);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W:0]   pc;
  logic [CNT_W:0]   sum;

  // Population count of accepted arrivals in this cycle
  always_comb begin
    pc = '0;
    for (int i = 0; i < N_REQ; i++) begin
      pc = pc + {{CNT_W{1'b0}}, take[i]};
    end
    sum  = {1'b0, count_q} + pc;
    done = (sum == FULL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      phase_q <= 1'b0;
    end else if (done) begin
      count_q <= '0;
      phase_q <= ~phase_q;
    end else begin
      count_q <= sum[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/sense_slots.sv
module sense_slots #(
  parameter int unsigned N_REQ = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_REQ-1:0] take,
  input  logic             done,
  input  logic             phase_q,
  output logic [N_REQ-1:0] arrived_q,
  output logic [N_REQ-1:0] release_q
);
  logic phase_nx;

  always_comb phase_nx = done ? ~phase_q : phase_q;

  for (genvar g = 0; g < N_REQ; g++) begin : g_slot
    logic lsense_q;
    logic lsense_nx;

    always_comb lsense_nx = take[g] ? phase_q : lsense_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        arrived_q[g] <= 1'b0;
        lsense_q     <= 1'b0;
        release_q[g] <= 1'b0;
      end else begin
        arrived_q[g] <= done ? 1'b0 : (arrived_q[g] | take[g]);
        lsense_q     <= lsense_nx;
        release_q[g] <= lsense_nx ^ phase_nx;
      end
    end
  end
endmodule

// File: rtl/episode_barrier.sv
module episode_barrier #(
  parameter int unsigned N_REQ = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_REQ-1:0] arrive_i,
  output logic             phase_o,
  output logic [N_REQ-1:0] release_o,
  output logic             dup_err_o
);
  logic [N_REQ-1:0] take;
  logic [N_REQ-1:0] arrived_q;
  logic             done;
  logic             phase_q;
  logic             err_q;
  logic [N_REQ-1:0] release_q;

  arrival_filter #(.N_REQ(N_REQ)) u_filter (
    .clk(clk), .rst(rst), .arrive(arrive_i), .arrived_q(arrived_q),
    .take(take), .err_q(err_q)
  );

  arrival_counter #(.N_REQ(N_REQ)) u_count (
    .clk(clk), .rst(rst), .take(take), .done(done), .phase_q(phase_q)
  );

  sense_slots #(.N_REQ(N_REQ)) u_slots (
    .clk(clk), .rst(rst), .take(take), .done(done), .phase_q(phase_q),
    .arrived_q(arrived_q), .release_q(release_q)
  );

  assign phase_o   = phase_q;
  assign release_o = release_q;
  assign dup_err_o = err_q;
endmodule

// File: rtl/barrier_chk.sv
module barrier_chk #(
  parameter int unsigned N_REQ = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [N_REQ-1:0] arrive_i,
  input logic [N_REQ-1:0] arrived_q,
  input logic             phase_o,
  input logic [N_REQ-1:0] release_o,
  input logic             dup_err_o
);
  AST_RELEASE_NEEDS_FLIP: assert property (@(posedge clk) disable iff (rst)
    (|(release_o & ~$past(release_o))) |-> !$stable(phase_o)); // R2

  AST_FLIP_RELEASES_ALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(phase_o) |-> (&release_o)); // R3

  AST_REPEAT_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (|(arrive_i & arrived_q)) |=> dup_err_o); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    dup_err_o |=> dup_err_o); // R7

  AST_RESET_CLEAN: assert property (@(posedge clk)
    $past(rst) |-> (!phase_o && release_o == '0 && !dup_err_o)); // R1
endmodule

bind episode_barrier barrier_chk #(.N_REQ(N_REQ)) u_chk (
  .clk(clk), .rst(rst), .arrive_i(arrive_i), .arrived_q(arrived_q),
  .phase_o(phase_o), .release_o(release_o), .dup_err_o(dup_err_o)
);

// File: tb/sim_episode_barrier.sv
module sim_episode_barrier;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] arrive = '0;
  logic         phase;
  logic [N-1:0] rel;
  logic         err;
  int           n_chk = 0;
  int           n_fail = 0;
  bit           finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  episode_barrier #(.N_REQ(N)) u0 (
    .clk(clk), .rst(rst), .arrive_i(arrive),
    .phase_o(phase), .release_o(rel), .dup_err_o(err)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Checks phase, release vector and error bit together
  task automatic chk_all(input string req, input logic p, input logic [N-1:0] r, input logic e);
    chk({req, " phase"}, {7'd0, phase}, {7'd0, p});
    chk({req, " release"}, {4'd0, rel}, {4'd0, r});
    chk({req, " err"}, {7'd0, err}, {7'd0, e});
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; arrive = '0;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  // Drive one-cycle arrive pulse; return at the negedge after the capturing edge
  task automatic pulse(input logic [N-1:0] m);
    @(negedge clk); arrive = m;
    @(negedge clk); arrive = '0;
  endtask

  task automatic t_reset();
    do_reset();
    chk_all("R1", 1'b0, 4'b0000, 1'b0);
  endtask

  task automatic t_sequential();
    do_reset();
    pulse(4'b0001); chk_all("R2 a1", 1'b0, 4'b0000, 1'b0);
    pulse(4'b0010); chk_all("R2 a2", 1'b0, 4'b0000, 1'b0);
    pulse(4'b0100); chk_all("R2 a3", 1'b0, 4'b0000, 1'b0);
    pulse(4'b1000); chk_all("R3 done", 1'b1, 4'b1111, 1'b0);
  endtask

  task automatic t_reuse();
    do_reset();
    pulse(4'b1111);
    pulse(4'b0001); chk_all("R4 rearrive", 1'b1, 4'b1110, 1'b0);
    pulse(4'b0010); chk_all("R8 slow keep", 1'b1, 4'b1100, 1'b0);
    pulse(4'b0100); chk_all("R8 slow keep2", 1'b1, 4'b1000, 1'b0);
    pulse(4'b1000); chk_all("R8 second done", 1'b0, 4'b1111, 1'b0);
  endtask

  task automatic t_simul();
    do_reset();
    pulse(4'b1111); chk_all("R5 all at once", 1'b1, 4'b1111, 1'b0);
    pulse(4'b0011); chk_all("R5 pair", 1'b1, 4'b1100, 1'b0);
    pulse(4'b1100); chk_all("R5 pair done", 1'b0, 4'b1111, 1'b0);
  endtask

  task automatic t_dup();
    do_reset();
    pulse(4'b0001);
    pulse(4'b0001); chk_all("R6 repeat", 1'b0, 4'b0000, 1'b1);
    pulse(4'b0010);
    pulse(4'b0100); chk_all("R6 not counted", 1'b0, 4'b0000, 1'b1);
    pulse(4'b1000); chk_all("R7 done sticky", 1'b1, 4'b1111, 1'b1);
    repeat (3) @(negedge clk);
    chk("R7 hold", {7'd0, err}, 8'd1);
    do_reset();
    chk("R7 reset clears", {7'd0, err}, 8'd0);
  endtask

  task automatic t_samecycle();
    do_reset();
    pulse(4'b0111);
    pulse(4'b1001); chk_all("R9 done+repeat", 1'b1, 4'b1111, 1'b1);
    pulse(4'b0110);
    pulse(4'b1000); chk_all("R9 no carry", 1'b1, 4'b0001, 1'b1);
    pulse(4'b0001); chk_all("R9 next done", 1'b0, 4'b1111, 1'b1);
  endtask

  initial begin
    t_reset();
    t_sequential();
    t_reuse();
    t_simul();
    t_dup();
    t_samecycle();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule